// File: doc/BRIEF.md
# Remote Storage Space Tracker

This block keeps the books for a linear store that a bus controller uses as shared storage on the network. The store is handled as a ring of `DEPTH` record slots. Records are appended at a write pointer and handed back, oldest first, at a release pointer. The block counts the occupied slots and publishes the free count together with the slot where the next write will start.

Three request strobes drive the block, and each carries a length. A write request is admitted only when its length fits in the remaining space. A read-done report sets a read flag on every slot it covers, so that later reads can tell records already consumed from fresh ones. A release returns the oldest slots to the free pool and clears their read flags. Space comes back only through a release.

Each strobe gets a single-cycle accept or reject pulse on the clock after it arrives. When strobes arrive in the same cycle, they are evaluated in the order release, then read-done, then write. Each later request sees the state left by the earlier ones. Between requests the block holds its state.

Top module: `space_trk`

## Requirements
- R1: After reset, `free_o` equals `DEPTH`, `wr_addr_o` is 0, every bit of `read_mark_o` is 0 and no response pulse is high.
- R2: Every strobe yields exactly one of its accept/reject pair, high for one cycle, on the clock after the strobe. A cycle without a strobe yields no pulse on that pair.
- R3: A write is accepted when 1 <= `wr_len_i` <= the free count left after any same-cycle release. An accepted write advances `wr_addr_o` by the length modulo `DEPTH` and lowers `free_o` by the length.
- R4: A refused write leaves `wr_addr_o` unchanged and takes nothing from the free count.
- R5: A read-done report with start slot `rd_addr_i` and length `rd_len_i` is accepted when the length is at least 1 and the span lies inside the occupied region. The test is (`rd_addr_i` - oldest slot) mod `DEPTH` + length <= occupied count. On acceptance, bit k of `read_mark_o` is set for slots `rd_addr_i` .. `rd_addr_i`+len-1 modulo `DEPTH`.
- R6: A refused read-done report changes no bit of `read_mark_o`.
- R7: A release is accepted when 1 <= `rel_len_i` <= the occupied count. It frees the `rel_len_i` oldest slots, raises `free_o` by the length and clears their read flags.
- R8: A release that is zero or larger than the occupied count is refused, and both the free count and the oldest-slot position stay unchanged.
- R9: For strobes in the same cycle, the release is applied first, the read-done test then uses the post-release region, and the write test uses the post-release free count.
- R10: `free_o` never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_req_i | input | 1 | Write request strobe |
| wr_len_i | input | CW | Write length in slots |
| rd_done_i | input | 1 | Read-done strobe |
| rd_addr_i | input | AW | First slot of the record that was read |
| rd_len_i | input | CW | Length of the record that was read |
| rel_req_i | input | 1 | Release strobe |
| rel_len_i | input | CW | Number of oldest slots to free |
| wr_ack_o | output | 1 | Write accepted pulse |
| wr_nak_o | output | 1 | Write refused pulse |
| rd_ack_o | output | 1 | Read-done accepted pulse |
| rd_nak_o | output | 1 | Read-done refused pulse |
| rel_ack_o | output | 1 | Release accepted pulse |
| rel_nak_o | output | 1 | Release refused pulse |
| free_o | output | CW | Free slot count |
| wr_addr_o | output | AW | Start slot of the next write |
| read_mark_o | output | DEPTH | Read flag per slot |

## Verification
The hardest state to reach is the one where the occupied region wraps past the top of the ring while strobes coincide in a cycle. In that state a read span that crosses slot 0 and a release that moves the oldest slot must both be evaluated against state that the same cycle changes. A long pseudo-random stream with an eight-slot ring drives all three strobes at once, with lengths from zero to past capacity. A modular arithmetic model predicts every pulse, the free count, the write start and each read flag, so the pointers wrap many times under mixed traffic. A short directed run first fills the ring exactly, then frees and refills it in one cycle.

// File: rtl/space_trk_pkg.sv
package space_trk_pkg;
  function automatic int unsigned ring_add(int unsigned p, int unsigned l, int unsigned d);
    int unsigned s;
    s = p + l;
    return (s >= d) ? s - d : s;
  endfunction

  // distance from base forward to a on a ring of d slots
  function automatic int unsigned ring_off(int unsigned a, int unsigned b, int unsigned d);
    return (a >= b) ? a - b : a + d - b;
  endfunction
endpackage

// File: rtl/space_ctr.sv
module space_ctr import space_trk_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [CW-1:0] wr_len_i,
  input  logic          rel_req_i,
  input  logic [CW-1:0] rel_len_i,
  output logic          wr_ack_o,
  output logic          wr_nak_o,
  output logic          rel_ack_o,
  output logic          rel_nak_o,
  output logic          rel_ok_o,
  output logic [CW-1:0] used_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] used_mid_o,
  output logic [AW-1:0] rptr_mid_o
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] used_q, used_d, used_mid;
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_mid;
  logic          rel_ok, wr_ok;

  // release is evaluated first, write sees the post-release state
  always_comb begin
    rel_ok   = rel_req_i && (rel_len_i != '0) && (rel_len_i <= used_q);
    used_mid = rel_ok ? used_q - rel_len_i : used_q;
    rptr_mid = rel_ok ? AW'(ring_add(32'(rptr_q), 32'(rel_len_i), DEPTH)) : rptr_q;
    wr_ok    = wr_req_i && (wr_len_i != '0) && (wr_len_i <= CAP - used_mid);
    used_d   = wr_ok ? used_mid + wr_len_i : used_mid;
    wptr_d   = wr_ok ? AW'(ring_add(32'(wptr_q), 32'(wr_len_i), DEPTH)) : wptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q    <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      wr_ack_o  <= 1'b0;
      wr_nak_o  <= 1'b0;
      rel_ack_o <= 1'b0;
      rel_nak_o <= 1'b0;
    end else begin
      used_q    <= used_d;
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_mid;
      wr_ack_o  <= wr_ok;
      wr_nak_o  <= wr_req_i && !wr_ok;
      rel_ack_o <= rel_ok;
      rel_nak_o <= rel_req_i && !rel_ok;
    end
  end

  assign rel_ok_o   = rel_ok;
  assign used_o     = used_q;
  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign used_mid_o = used_mid;
  assign rptr_mid_o = rptr_mid;

  // R10
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) used_q <= CAP);
  // R8
  rel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_nak_o |-> rptr_q == $past(rptr_q));
  // R4
  wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_nak_o |-> wptr_q == $past(wptr_q));
  // R2
  wr_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> (wr_ack_o ^ wr_nak_o));
  // R2
  rel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_req_i |=> !(rel_ack_o || rel_nak_o));
endmodule

// File: rtl/rd_gate.sv
module rd_gate import space_trk_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_done_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [CW-1:0] rd_len_i,
  input  logic [CW-1:0] used_mid_i,
  input  logic [AW-1:0] rptr_mid_i,
  output logic          rd_ok_o,
  output logic          rd_ack_o,
  output logic          rd_nak_o
);
  int unsigned off;

  always_comb begin
    off     = ring_off(32'(rd_addr_i), 32'(rptr_mid_i), DEPTH);
    rd_ok_o = rd_done_i && (rd_len_i != '0) &&
              (off + 32'(rd_len_i) <= 32'(used_mid_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ack_o <= 1'b0;
      rd_nak_o <= 1'b0;
    end else begin
      rd_ack_o <= rd_ok_o;
      rd_nak_o <= rd_done_i && !rd_ok_o;
    end
  end

  // R2
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |=> (rd_ack_o ^ rd_nak_o));
endmodule

// File: rtl/mark_array.sv
module mark_array import space_trk_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [AW-1:0]    set_base_i,
  input  logic [CW-1:0]    set_len_i,
  input  logic             clr_en_i,
  input  logic [AW-1:0]    clr_base_i,
  input  logic [CW-1:0]    clr_len_i,
  output logic [DEPTH-1:0] marks_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic set_hit, clr_hit, mark_q;

    always_comb begin
      set_hit = set_en_i && (ring_off(i, 32'(set_base_i), DEPTH) < 32'(set_len_i));
      clr_hit = clr_en_i && (ring_off(i, 32'(clr_base_i), DEPTH) < 32'(clr_len_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mark_q <= 1'b0;
      else if (set_hit) mark_q <= 1'b1;
      else if (clr_hit) mark_q <= 1'b0;
    end

    assign marks_o[i] = mark_q;
  end
endmodule

// File: rtl/space_trk.sv
module space_trk #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [CW-1:0]    wr_len_i,
  input  logic             rd_done_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [CW-1:0]    rd_len_i,
  input  logic             rel_req_i,
  input  logic [CW-1:0]    rel_len_i,
  output logic             wr_ack_o,
  output logic             wr_nak_o,
  output logic             rd_ack_o,
  output logic             rd_nak_o,
  output logic             rel_ack_o,
  output logic             rel_nak_o,
  output logic [CW-1:0]    free_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DEPTH-1:0] read_mark_o
);
  logic          rel_ok, rd_ok;
  logic [CW-1:0] used, used_mid;
  logic [AW-1:0] rptr, rptr_mid;

  space_ctr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req_i),
    .wr_len_i   (wr_len_i),
    .rel_req_i  (rel_req_i),
    .rel_len_i  (rel_len_i),
    .wr_ack_o   (wr_ack_o),
    .wr_nak_o   (wr_nak_o),
    .rel_ack_o  (rel_ack_o),
    .rel_nak_o  (rel_nak_o),
    .rel_ok_o   (rel_ok),
    .used_o     (used),
    .wptr_o     (wr_addr_o),
    .rptr_o     (rptr),
    .used_mid_o (used_mid),
    .rptr_mid_o (rptr_mid)
  );

  rd_gate #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_done_i  (rd_done_i),
    .rd_addr_i  (rd_addr_i),
    .rd_len_i   (rd_len_i),
    .used_mid_i (used_mid),
    .rptr_mid_i (rptr_mid),
    .rd_ok_o    (rd_ok),
    .rd_ack_o   (rd_ack_o),
    .rd_nak_o   (rd_nak_o)
  );

  mark_array #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_marks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (rd_ok),
    .set_base_i (rd_addr_i),
    .set_len_i  (rd_len_i),
    .clr_en_i   (rel_ok),
    .clr_base_i (rptr),
    .clr_len_i  (rel_len_i),
    .marks_o    (read_mark_o)
  );

  assign free_o = CW'(DEPTH) - used;

  // R6
  rd_nak_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_nak_o && !rel_ack_o) |-> read_mark_o == $past(read_mark_o));
endmodule

// File: tb/space_trk_tb.sv
module space_trk_tb;
  localparam int DEPTH   = 8;
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int CLK_PER = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_req_i = 0, rd_done_i = 0, rel_req_i = 0;
  logic [CW-1:0] wr_len_i = '0, rd_len_i = '0, rel_len_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic wr_ack_o, wr_nak_o, rd_ack_o, rd_nak_o, rel_ack_o, rel_nak_o;
  logic [CW-1:0] free_o;
  logic [AW-1:0] wr_addr_o;
  logic [DEPTH-1:0] read_mark_o;

  int n_chk = 0, n_fail = 0;
  int m_used = 0, m_wp = 0, m_rp = 0;
  logic [DEPTH-1:0] m_mk = '0;
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  space_trk #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit wr, int wl, bit rd, int ra, int rl, bit rel, int ql);
    bit e_rel, e_rd, e_wr;
    int off;
    wr_req_i = wr;  wr_len_i = CW'(wl);
    rd_done_i = rd; rd_addr_i = AW'(ra); rd_len_i = CW'(rl);
    rel_req_i = rel; rel_len_i = CW'(ql);
    e_rel = rel && ql >= 1 && ql <= m_used;
    if (e_rel) begin
      for (int k = 0; k < ql; k++) m_mk[(m_rp + k) % DEPTH] = 1'b0;
      m_rp = (m_rp + ql) % DEPTH;
      m_used -= ql;
    end
    off  = (ra - m_rp + DEPTH) % DEPTH;
    e_rd = rd && rl >= 1 && off + rl <= m_used;
    if (e_rd) for (int k = 0; k < rl; k++) m_mk[(ra + k) % DEPTH] = 1'b1;
    e_wr = wr && wl >= 1 && wl <= DEPTH - m_used;
    if (e_wr) begin
      m_wp = (m_wp + wl) % DEPTH;
      m_used += wl;
    end
    @(negedge clk_i);
    chk("R7", rel_ack_o, int'(e_rel));
    chk("R8", rel_nak_o, int'(rel && !e_rel));
    chk("R5", rd_ack_o, int'(e_rd));
    chk("R6", rd_nak_o, int'(rd && !e_rd));
    chk("R3", wr_ack_o, int'(e_wr));
    chk("R4", wr_nak_o, int'(wr && !e_wr));
    chk("R3", free_o, DEPTH - m_used);
    chk("R4", wr_addr_o, m_wp);
    chk("R5", read_mark_o, m_mk);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    chk("R1", free_o, DEPTH);
    chk("R1", wr_addr_o, 0);
    chk("R1", read_mark_o, 0);
    chk("R1", {wr_ack_o, wr_nak_o, rd_ack_o, rd_nak_o, rel_ack_o, rel_nak_o}, 0);

    step(1, 3, 0, 0, 0, 0, 0);  chk("R3", free_o, 5);
    step(1, 6, 0, 0, 0, 0, 0);  chk("R4", free_o, 5);
    step(1, 5, 0, 0, 0, 0, 0);  chk("R3", free_o, 0);
    step(1, 1, 0, 0, 0, 0, 0);  chk("R4", wr_nak_o, 1);
    step(0, 0, 1, 0, 2, 0, 0);  chk("R5", read_mark_o, 8'h03);
    step(0, 0, 1, 7, 2, 0, 0);  chk("R6", read_mark_o, 8'h03);
    step(0, 0, 0, 0, 0, 1, 9);  chk("R8", free_o, 0);
    step(0, 0, 0, 0, 0, 1, 0);  chk("R8", rel_nak_o, 1);
    step(0, 0, 0, 0, 0, 1, 3);  chk("R7", read_mark_o, 0);
    chk("R7", free_o, 3);
    // release and write together: write fits only after the release
    step(1, 5, 0, 0, 0, 1, 2);  chk("R9", wr_ack_o, 1);
    chk("R9", free_o, 0);
    // release moves the oldest slot past the read span
    step(0, 0, 1, 5, 1, 1, 1);  chk("R9", rd_nak_o, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R2", {wr_ack_o, wr_nak_o, rd_ack_o, rd_nak_o, rel_ack_o, rel_nak_o}, 0);

    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      seed = seed * 32'd1103515245 + 32'd12345;
      r = seed >> 8;
      step(r[0], int'(r[4:1] % 10), r[5], int'(r[8:6]), int'(r[12:9] % 10),
           r[13] & r[14], int'(r[18:15] % 10));
      // R10
      chk("R10", int'(free_o <= CW'(DEPTH)), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule